// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time as a chain of packed BCD counters: seconds, minutes, hours (00 to 23), day of week (1 to 7), date, month and two-digit year. A clock-enable pulse at 32.768 kHz feeds a binary prescaler. When the prescaler wraps, it issues one tick per second, and that tick ripples through the counters in the same clock cycle. The date wraps at the real length of the current month, and February follows a divide-by-four leap rule.

A register front end owns the control bits and drives them in as levels. The stop input freezes the prescaler and so the whole chain. The frequency-test input replaces bit 0 of the seconds output with a prescaler phase bit that toggles every 32 enabled ticks. A single load strobe writes every field in one clock and restarts the prescaler. All outputs are registered fields, apart from the seconds LSB multiplexer.

Top module: `rtc_bcd_chain`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00.
- R2: Seconds advance by one on the clock edge that takes the 2^PRESC_W-th enabled tick (tick_32k high) since the prescaler last started from zero; cycles with tick_32k low do not count.
- R3: Seconds and minutes count 00 to 59 in BCD; wrapping from 59 to 00 advances the next field by one.
- R4: Hours count 00 to 23; the wrap from 23 to 00 advances the date and the day of week; day of week counts 1 to 7 and wraps to 1, independent of the date.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in months 01, 03, 05, 07, 08, 10 and 12; the wrap advances the month.
- R6: In month 02 the date wraps after 29 when the BCD year is a multiple of four (00 included), otherwise after 28.
- R7: Month wraps from 12 to 01 and advances the year; year wraps from 99 to 00.
- R8: A load strobe replaces all seven fields on the next clock edge and clears the prescaler, so the first following second arrives 2^PRESC_W enabled ticks later.
- R9: While stop is high and no load occurs, the prescaler and every output hold; a load still applies.
- R10: With ftest high and stop low, bit 0 of sec_o shows prescaler bit FT_BIT (toggling every 2^FT_BIT enabled ticks) and bits 7:1 show the seconds field; with stop high ftest has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz period |
| stop | input | 1 | Freezes the prescaler and the chain |
| ftest | input | 1 | Frequency-test select for the seconds LSB |
| load | input | 1 | Parallel load strobe for all fields |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load |
| ld_wday | input | 8 | BCD day of week to load |
| ld_date | input | 8 | BCD date to load |
| ld_month | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| sec_o | output | 8 | Seconds, LSB replaced in frequency test |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| date_o | output | 8 | Date |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |

## Verification
A load shows on every output one edge after the strobe is sampled. From then on, all fields change together on the edge that takes the 2^PRESC_W-th enabled tick. So the bench checks once after 2^PRESC_W - 1 edges, when nothing may have moved, and again one edge later. The frequency-test bit turns over after exactly 2^FT_BIT edges with the tick held high. The stop multiplexer acts in the same cycle. Inputs change on the falling edge and outputs are read just after it, so every sample falls half a period clear of the edge that produced it.

// File: rtl/rtc_chain_pkg.sv
package rtc_chain_pkg;
  typedef logic [7:0] bcd8_t;

  localparam int NFIELD   = 7;
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HR   = 2;
  localparam int FLD_DOW  = 3;
  localparam int FLD_DATE = 4;
  localparam int FLD_MON  = 5;
  localparam int FLD_YR   = 6;

  // Add one to a packed two-digit BCD value
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Multiple of four: even tens needs units 0/4/8, odd tens needs 2/6
  function automatic logic bcd_year_leap(input bcd8_t y);
    case (y[3:0])
      4'd0, 4'd4, 4'd8: return ~y[4];
      4'd2, 4'd6:       return y[4];
      default:          return 1'b0;
    endcase
  endfunction

  function automatic bcd8_t month_last_day(input bcd8_t m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd8_t field_first(input int idx);
    if (idx == FLD_DOW || idx == FLD_DATE || idx == FLD_MON) return 8'h01;
    else return 8'h00;
  endfunction

  function automatic bcd8_t field_last(input int idx);
    case (idx)
      FLD_SEC, FLD_MIN: return 8'h59;
      FLD_HR:           return 8'h23;
      FLD_DOW:          return 8'h07;
      FLD_MON:          return 8'h12;
      FLD_YR:           return 8'h99;
      default:          return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_W  = 15,
  parameter int FT_BIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic run,
  input  logic clear,
  output logic sec_tick,
  output logic ft_phase
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             adv;

  always_comb begin
    adv   = tick_en && run;
    cnt_d = cnt_q;
    if (clear)    cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sec_tick = adv && !clear && (cnt_q == CNT_TOP);
  assign ft_phase = cnt_q[FT_BIT];
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field import rtc_chain_pkg::*; #(
  parameter bcd8_t FIRST = 8'h00
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  bcd8_t load_val,
  input  logic  step,
  input  bcd8_t last_val,
  output bcd8_t val
);
  bcd8_t val_q;
  bcd8_t val_d;

  always_comb begin
    val_d = val_q;
    if (load)      val_d = load_val;
    else if (step) val_d = (val_q == last_val) ? FIRST : bcd_inc(val_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= FIRST;
    else        val_q <= val_d;
  end

  assign val = val_q;
endmodule

// File: rtl/rtc_month_limit.sv
module rtc_month_limit import rtc_chain_pkg::*; (
  input  bcd8_t month,
  input  bcd8_t year,
  output bcd8_t last_date
);
  assign last_date = month_last_day(month, bcd_year_leap(year));
endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain import rtc_chain_pkg::*; #(
  parameter int PRESC_W = 15,
  parameter int FT_BIT  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       stop,
  input  logic       ftest,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  bcd8_t [NFIELD-1:0] fld_q;
  bcd8_t [NFIELD-1:0] ld_vec;
  bcd8_t [NFIELD-1:0] last_vec;
  logic  [NFIELD-1:0] step_vec;
  bcd8_t              date_last;
  logic               sec_tick;
  logic               ft_phase;
  logic               step_min, step_hr, step_day, step_mon, step_yr;

  rtc_prescaler #(.CNT_W(PRESC_W), .FT_BIT(FT_BIT)) presc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_32k),
    .run      (!stop),
    .clear    (load),
    .sec_tick (sec_tick),
    .ft_phase (ft_phase)
  );

  rtc_month_limit mlim_i (
    .month     (fld_q[FLD_MON]),
    .year      (fld_q[FLD_YR]),
    .last_date (date_last)
  );

  assign ld_vec = {ld_year, ld_month, ld_date, ld_wday, ld_hour, ld_min, ld_sec};

  // Ripple carry enables: all fields settle in the cycle of the tick
  always_comb begin
    step_min = sec_tick && (fld_q[FLD_SEC]  == field_last(FLD_SEC));
    step_hr  = step_min && (fld_q[FLD_MIN]  == field_last(FLD_MIN));
    step_day = step_hr  && (fld_q[FLD_HR]   == field_last(FLD_HR));
    step_mon = step_day && (fld_q[FLD_DATE] == date_last);
    step_yr  = step_mon && (fld_q[FLD_MON]  == field_last(FLD_MON));
  end

  assign step_vec = {step_yr, step_mon, step_day, step_day, step_hr, step_min, sec_tick};

  for (genvar gi = 0; gi < NFIELD; gi++) begin : g_field
    if (gi == FLD_DATE) begin : g_dyn
      assign last_vec[gi] = date_last;
    end else begin : g_fix
      assign last_vec[gi] = field_last(gi);
    end

    rtc_bcd_field #(.FIRST(field_first(gi))) fld_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (ld_vec[gi]),
      .step     (step_vec[gi]),
      .last_val (last_vec[gi]),
      .val      (fld_q[gi])
    );
  end

  assign sec_o   = (ftest && !stop) ? {fld_q[FLD_SEC][7:1], ft_phase} : fld_q[FLD_SEC];
  assign min_o   = fld_q[FLD_MIN];
  assign hour_o  = fld_q[FLD_HR];
  assign wday_o  = fld_q[FLD_DOW];
  assign date_o  = fld_q[FLD_DATE];
  assign month_o = fld_q[FLD_MON];
  assign year_o  = fld_q[FLD_YR];
endmodule

// File: rtl/rtc_chain_chk.sv
module rtc_chain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic       stop,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_min,
  input logic [7:0] ld_hour,
  input logic [7:0] ld_wday,
  input logic [7:0] ld_date,
  input logic [7:0] ld_month,
  input logic [7:0] ld_year,
  input logic [7:0] sec_raw,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  // R8
  load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sec_raw == $past(ld_sec) && min_o == $past(ld_min) &&
              hour_o == $past(ld_hour) && wday_o == $past(ld_wday) &&
              date_o == $past(ld_date) && month_o == $past(ld_month) &&
              year_o == $past(ld_year)));

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !load) |=> $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));

  // R3
  min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (min_o != $past(min_o) && !$past(load)) |-> ($past(sec_raw) == 8'h59));

  // R4
  day_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (date_o != $past(date_o) && !$past(load)) |->
      ($past(hour_o) == 8'h23 && $past(min_o) == 8'h59 && $past(sec_raw) == 8'h59));

  // R10
  ftest_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> (sec_o == sec_raw));
endmodule

bind rtc_bcd_chain rtc_chain_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .load     (load),
  .stop     (stop),
  .ld_sec   (ld_sec),
  .ld_min   (ld_min),
  .ld_hour  (ld_hour),
  .ld_wday  (ld_wday),
  .ld_date  (ld_date),
  .ld_month (ld_month),
  .ld_year  (ld_year),
  .sec_raw  (fld_q[0]),
  .sec_o    (sec_o),
  .min_o    (min_o),
  .hour_o   (hour_o),
  .wday_o   (wday_o),
  .date_o   (date_o),
  .month_o  (month_o),
  .year_o   (year_o)
);

// File: tb/rtc_bcd_chain_tb_top.sv
`timescale 1ns/1ps
module rtc_bcd_chain_tb_top;
  localparam int PW  = 6;
  localparam int FTB = 5;
  localparam int TPS = 1 << PW;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_32k, stop, ftest, load;
  logic [7:0] ld_sec, ld_min, ld_hour, ld_wday, ld_date, ld_month, ld_year;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rtc_bcd_chain #(.PRESC_W(PW), .FT_BIT(FTB)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .stop(stop), .ftest(ftest),
    .load(load), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
    .ld_wday(ld_wday), .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  // Packed view: year, month, date, weekday, hour, minute, second
  function automatic logic [55:0] now_vec();
    return {year_o, month_o, date_o, wday_o, hour_o, min_o, sec_o};
  endfunction

  task automatic chk(input string req, input logic [55:0] got, input logic [55:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_load(input logic [55:0] v);
    @(negedge clk);
    {ld_year, ld_month, ld_date, ld_wday, ld_hour, ld_min, ld_sec} = v;
    load = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0;
    #1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic roll(input string req, input logic [55:0] start, input logic [55:0] exp);
    do_load(start);
    edges(TPS);
    chk(req, now_vec(), exp);
  endtask

  task automatic t_reset();
    chk("R1 reset fields", now_vec(), 56'h00_01_01_01_00_00_00);
  endtask

  task automatic t_prescale();
    do_load(56'h21_06_15_03_10_20_30);
    chk("R8 load applied", now_vec(), 56'h21_06_15_03_10_20_30);
    edges(TPS - 1);
    chk("R8 no tick before full second", now_vec(), 56'h21_06_15_03_10_20_30);
    edges(1);
    chk("R2 tick on last count", now_vec(), 56'h21_06_15_03_10_20_31);
    tick_32k = 1'b0;
    edges(3 * TPS);
    chk("R2 idle tick ignored", now_vec(), 56'h21_06_15_03_10_20_31);
    edges(TPS - 1);
    tick_32k = 1'b1;
    edges(TPS - 1);
    chk("R2 partial second", now_vec(), 56'h21_06_15_03_10_20_31);
    edges(1);
    chk("R2 second after gap", now_vec(), 56'h21_06_15_03_10_20_32);
  endtask

  task automatic t_carry();
    roll("R3 minute carry", 56'h21_06_15_03_12_34_59, 56'h21_06_15_03_12_35_00);
    roll("R3 hour carry bcd", 56'h21_06_15_03_09_59_59, 56'h21_06_15_03_10_00_00);
    roll("R3 seconds units", 56'h21_06_15_03_09_59_09, 56'h21_06_15_03_09_59_10);
  endtask

  task automatic t_day();
    roll("R4 midnight date weekday", 56'h21_06_10_03_23_59_59, 56'h21_06_11_04_00_00_00);
    roll("R4 weekday wrap", 56'h21_06_12_07_23_59_59, 56'h21_06_13_01_00_00_00);
    roll("R7 year end", 56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00);
    roll("R7 month into year", 56'h45_12_31_02_23_59_59, 56'h46_01_01_03_00_00_00);
  endtask

  task automatic t_month_len();
    roll("R5 april end", 56'h21_04_30_02_23_59_59, 56'h21_05_01_03_00_00_00);
    roll("R5 november end", 56'h21_11_30_02_23_59_59, 56'h21_12_01_03_00_00_00);
    roll("R5 january 30", 56'h21_01_30_02_23_59_59, 56'h21_01_31_03_00_00_00);
    roll("R5 january end", 56'h21_01_31_02_23_59_59, 56'h21_02_01_03_00_00_00);
    roll("R5 july 30", 56'h21_07_30_02_23_59_59, 56'h21_07_31_03_00_00_00);
  endtask

  task automatic t_leap();
    roll("R6 leap 24 feb28", 56'h24_02_28_02_23_59_59, 56'h24_02_29_03_00_00_00);
    roll("R6 leap 24 feb29", 56'h24_02_29_02_23_59_59, 56'h24_03_01_03_00_00_00);
    roll("R6 plain 23 feb28", 56'h23_02_28_02_23_59_59, 56'h23_03_01_03_00_00_00);
    roll("R6 leap 00", 56'h00_02_28_02_23_59_59, 56'h00_02_29_03_00_00_00);
    roll("R6 plain 10", 56'h10_02_28_02_23_59_59, 56'h10_03_01_03_00_00_00);
    roll("R6 leap 12", 56'h12_02_28_02_23_59_59, 56'h12_02_29_03_00_00_00);
  endtask

  task automatic t_stop();
    do_load(56'h30_08_20_05_11_22_33);
    stop = 1'b1;
    edges(3 * TPS);
    chk("R9 frozen", now_vec(), 56'h30_08_20_05_11_22_33);
    do_load(56'h30_08_20_05_11_22_40);
    chk("R9 load while stopped", now_vec(), 56'h30_08_20_05_11_22_40);
    edges(TPS + 5);
    chk("R9 still frozen", now_vec(), 56'h30_08_20_05_11_22_40);
    @(negedge clk);
    stop = 1'b0;
    edges(TPS - 1);
    chk("R9 resumed partial", now_vec(), 56'h30_08_20_05_11_22_40);
    edges(1);
    chk("R9 resumed tick", now_vec(), 56'h30_08_20_05_11_22_41);
  endtask

  task automatic t_ftest();
    @(negedge clk);
    ftest = 1'b1;
    do_load(56'h30_08_20_05_11_22_21);
    chk("R10 phase low", {48'h0, sec_o}, 56'h20);
    edges((1 << FTB) - 1);
    chk("R10 phase still low", {48'h0, sec_o}, 56'h20);
    edges(1);
    chk("R10 phase high", {48'h0, sec_o}, 56'h21);
    edges(1 << FTB);
    chk("R10 after second", {48'h0, sec_o}, 56'h22);
    edges(1 << FTB);
    chk("R10 phase high again", {48'h0, sec_o}, 56'h23);
    @(negedge clk);
    stop = 1'b1;
    #1;
    chk("R10 no effect when stopped", {48'h0, sec_o}, 56'h22);
    @(negedge clk);
    stop  = 1'b0;
    ftest = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick_32k = 1'b0; stop = 1'b0; ftest = 1'b0; load = 1'b0;
    {ld_year, ld_month, ld_date, ld_wday, ld_hour, ld_min, ld_sec} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    tick_32k = 1'b1;
    t_prescale();
    t_carry();
    t_day();
    t_month_len();
    t_leap();
    t_stop();
    t_ftest();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule